// File: doc/BRIEF.md
# Key-Locked Two-Stage Watchdog Timer

This block is a watchdog timer that sits on a simple single-cycle register bus. Software programs a reload count, then turns on counting. The counter counts down by one on every clock. When it passes zero it reloads itself and raises a pending interrupt. The pending flag is the first stage of the expiry. Software services the watchdog by writing to the clear register. That write drops the pending flag and restarts the count from the reload value.

If the count expires a second time while the first interrupt is still pending, the block escalates to a reset request, provided that reset is enabled. The reset request is a level output that stays high until the system reset. A program that has stopped running is therefore reset after about two reload periods.

Every write to the control registers is blocked until a fixed 32-bit key has been written to the lock register. Writing any other value to that register closes the lock again. Reads are always allowed. A write is one cycle with `bus_we` high and takes effect at that clock edge. Read data is combinational from `bus_addr`.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, the lock register (0xC00) reads 1 and the control register (0x008) reads 0. The reload register (0x000) and the count register (0x004) both read 0xFFFFFFFF. `irq` and `rst_req` are both 0.
- R2: Writing 0x1ACCE551 to 0xC00 opens the lock, and 0xC00 then reads 0. Writing any other value to 0xC00 closes the lock, and 0xC00 then reads 1.
- R3: While the lock is closed, writes to 0x000, 0x008 and 0x00C change nothing. Reads stay allowed.
- R4: Control bit 0 enables counting and the `irq` output. Control bit 1 enables the reset request. Control bits 31:2 always read 0.
- R5: A write to 0x000 stores the reload value and restarts the count from that value. Register 0x004 returns the current count and ignores writes.
- R6: While counting is enabled, the count drops by one per clock. With reload value N, the first expiry comes N+1 clocks after counting starts. At that expiry the pending flag is set, `irq` rises and the count reloads to N.
- R7: If an expiry occurs while the pending flag is set and control bit 1 is 1, `rst_req` rises, 2(N+1) clocks after counting starts. `rst_req` then stays 1 until reset.
- R8: If control bit 1 is 0, a second expiry with the flag pending never raises `rst_req`, and the flag stays set.
- R9: A write of any data to 0x00C clears the pending flag and reloads the count. When that write lands in the same cycle as an expiry, the clear wins and no reset request is made.
- R10: Clearing control bit 0 freezes the count and forces `irq` low. The pending flag is kept, and `irq` returns when counting is enabled again.
- R11: Bit 0 of the status register (0x014) shows the raw pending flag, whatever the enable is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt: pending flag gated by enable |
| rst_req | output | 1 | Sticky reset request |

## Verification
The main trial sweeps reload values 0 to 5, each with reset enable on and off. The clock counts to the `irq` edge and to the `rst_req` edge then separate an off-by-one in the expiry period from a wrong reload value, and separate a missing escalation from one that ignores the enable. A second set of patterns aims a clear write at the very cycle of the second expiry, which shows whether clear takes priority over escalation. Other patterns write with the lock closed, and write reserved control bits. The last pattern turns the enable off while the flag is pending, then reads the frozen count and the kept status.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned REG_ADDR_W = 12;
  localparam int unsigned REG_DATA_W = 32;

  localparam logic [REG_ADDR_W-1:0] OFF_RELOAD = 12'h000;
  localparam logic [REG_ADDR_W-1:0] OFF_COUNT  = 12'h004;
  localparam logic [REG_ADDR_W-1:0] OFF_CTRL   = 12'h008;
  localparam logic [REG_ADDR_W-1:0] OFF_ACK    = 12'h00C;
  localparam logic [REG_ADDR_W-1:0] OFF_STAT   = 12'h014;
  localparam logic [REG_ADDR_W-1:0] OFF_GUARD  = 12'hC00;

  localparam logic [REG_DATA_W-1:0] GUARD_KEY = 32'h1ACC_E551;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_RELOAD, SEL_COUNT, SEL_CTRL, SEL_ACK, SEL_STAT, SEL_GUARD
  } reg_sel_e;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [REG_DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]      count,
  input  logic                  pending,
  output logic [REG_DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]      reload_val,
  output logic                  cnt_en,
  output logic                  rst_en,
  output logic                  restart,
  output logic [CNT_W-1:0]      restart_val,
  output logic                  ack
);
  reg_sel_e         sel;
  logic             locked_q, locked_d;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic [1:0]       ctrl_q, ctrl_d;
  logic             wr_ok;

  always_comb begin
    unique case (addr)
      OFF_RELOAD: sel = SEL_RELOAD;
      OFF_COUNT:  sel = SEL_COUNT;
      OFF_CTRL:   sel = SEL_CTRL;
      OFF_ACK:    sel = SEL_ACK;
      OFF_STAT:   sel = SEL_STAT;
      OFF_GUARD:  sel = SEL_GUARD;
      default:    sel = SEL_NONE;
    endcase
  end

  assign wr_ok = we && !locked_q;

  always_comb begin
    locked_d    = locked_q;
    reload_d    = reload_q;
    ctrl_d      = ctrl_q;
    restart     = 1'b0;
    restart_val = reload_q;
    ack         = 1'b0;
    if (we && sel == SEL_GUARD) locked_d = (wdata != GUARD_KEY);
    if (wr_ok) begin
      case (sel)
        SEL_RELOAD: begin
          reload_d    = wdata[CNT_W-1:0];
          restart     = 1'b1;
          restart_val = wdata[CNT_W-1:0];
        end
        SEL_CTRL: ctrl_d = wdata[1:0];
        SEL_ACK: begin
          ack     = 1'b1;
          restart = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
      reload_q <= '1;
      ctrl_q   <= '0;
    end else begin
      locked_q <= locked_d;
      reload_q <= reload_d;
      ctrl_q   <= ctrl_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_RELOAD: rdata[CNT_W-1:0] = reload_q;
      SEL_COUNT:  rdata[CNT_W-1:0] = count;
      SEL_CTRL:   rdata[1:0]       = ctrl_q;
      SEL_STAT:   rdata[0]         = pending;
      SEL_GUARD:  rdata[0]         = locked_q;
      default:    rdata = '0;
    endcase
  end

  assign reload_val = reload_q;
  assign cnt_en     = ctrl_q[0];
  assign rst_en     = ctrl_q[1];

  // R3: a closed lock blocks every protected write
  a_r3_locked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && locked_q && sel != SEL_GUARD) |=> ($stable(reload_q) && $stable(ctrl_q)));
  // R2: the key opens, anything else closes
  a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_GUARD && wdata == GUARD_KEY) |=> !locked_q);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rst_en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             restart,
  input  logic [CNT_W-1:0] restart_val,
  input  logic             ack,
  output logic [CNT_W-1:0] count,
  output logic             pending,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             rreq_q, rreq_d;
  logic             expire;

  assign expire = en && !restart && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    rreq_d = rreq_q;
    if (restart) begin
      cnt_d = restart_val;
    end else if (en) begin
      cnt_d = (cnt_q == '0) ? reload_val : cnt_q - 1'b1;
    end
    if (expire) begin
      if (!pend_q)     pend_d = 1'b1;
      else if (rst_en) rreq_d = 1'b1;
    end
    if (ack) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      pend_q <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      rreq_q <= rreq_d;
    end
  end

  assign count   = cnt_q;
  assign pending = pend_q;
  assign rst_req = rreq_q;

  // R7: once raised, the reset request holds
  a_r7_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_q |=> rreq_q);
  // R7: escalation only from an already pending flag
  a_r7_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rreq_q) |-> ($past(pend_q) && $past(rst_en)));
  // R10: frozen count while disabled and untouched
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart) |=> $stable(cnt_q));
  // R9: clear always drops the pending flag
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !pend_q);
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [REG_DATA_W-1:0] bus_wdata,
  output logic [REG_DATA_W-1:0] bus_rdata,
  output logic                  irq,
  output logic                  rst_req
);
  logic             rst_n_s;
  logic [CNT_W-1:0] count, reload_val, restart_val;
  logic             pending, cnt_en, rst_en, restart, ack;

  wdog_rst_sync #(.STAGES(2)) i_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  wdog_regs #(.CNT_W(CNT_W)) i_regs (
    .clk(clk), .rst_n(rst_n_s), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .count(count), .pending(pending),
    .rdata(bus_rdata), .reload_val(reload_val), .cnt_en(cnt_en),
    .rst_en(rst_en), .restart(restart), .restart_val(restart_val), .ack(ack)
  );

  wdog_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n_s), .en(cnt_en), .rst_en(rst_en),
    .reload_val(reload_val), .restart(restart), .restart_val(restart_val),
    .ack(ack), .count(count), .pending(pending), .rst_req(rst_req)
  );

  assign irq = pending && cnt_en;

  // R10: irq never shows while counting is off
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq |-> cnt_en);
endmodule

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;
  int          total = 0;
  int          bad = 0;
  logic        done = 1'b0;

  localparam logic [31:0] KEY = 32'h1ACCE551;

  always #2.5 clk = ~clk;

  wdog_two_stage i_wdog_two_stage (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // start counting: returns at negedge after the enabling edge
  task automatic start(input int n, input logic rsten);
    do_reset();
    wr(12'hC00, KEY);
    wr(12'h000, n);
    wr(12'h008, {30'd0, rsten, 1'b1});
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int k;
    do_reset();
    // R1 reset state
    rd(12'hC00, v); check("R1 lock", v, 1);
    rd(12'h008, v); check("R1 ctrl", v, 0);
    rd(12'h000, v); check("R1 reload", v, 32'hFFFFFFFF);
    rd(12'h004, v); check("R1 count", v, 32'hFFFFFFFF);
    check("R1 irq", irq, 0);
    check("R1 rst_req", rst_req, 0);
    // R3 locked writes ignored
    wr(12'h000, 7); wr(12'h008, 3);
    rd(12'h000, v); check("R3 reload locked", v, 32'hFFFFFFFF);
    rd(12'h008, v); check("R3 ctrl locked", v, 0);
    rd(12'h004, v); check("R3 count untouched", v, 32'hFFFFFFFF);
    // R2 lock behaviour
    wr(12'hC00, KEY);  rd(12'hC00, v); check("R2 open", v, 0);
    wr(12'hC00, 32'h1ACCE550); rd(12'hC00, v); check("R2 close", v, 1);
    wr(12'hC00, KEY);
    // R5 reload write restarts count, count ignores writes
    wr(12'h000, 32'h1234); rd(12'h004, v); check("R5 count restart", v, 32'h1234);
    wr(12'h004, 32'h55);   rd(12'h004, v); check("R5 count read-only", v, 32'h1234);
    // R4 reserved bits
    wr(12'h008, 32'hFFFFFFFC); rd(12'h008, v); check("R4 reserved", v, 0);
    wr(12'h008, 32'hFFFFFFFE); rd(12'h008, v); check("R4 rsten only", v, 2);
    rd(12'h004, v); check("R4 no count without bit0", v, 32'h1234);

    // R6/R7/R8 sweep
    for (int n = 0; n <= 5; n++) begin
      for (int re = 0; re <= 1; re++) begin
        start(n, re[0]);
        k = 0;
        while (!irq && k < 50) begin @(negedge clk); k++; end
        check($sformatf("R6 first expiry n=%0d", n), k, n + 1);
        rd(12'h004, v); check("R6 reload at expiry", v, n);
        rd(12'h014, v); check("R11 status", v, 1);
        if (re == 1) begin
          while (!rst_req && k < 100) begin @(negedge clk); k++; end
          check($sformatf("R7 second expiry n=%0d", n), k, 2 * n + 2);
          repeat (10) @(negedge clk);
          check("R7 sticky", rst_req, 1);
        end else begin
          repeat (2 * n + 6) @(negedge clk);
          check("R8 no reset", rst_req, 0);
          check("R8 still pending", irq, 1);
        end
      end
    end

    // R9 clear on the second-expiry cycle
    start(3, 1'b1);
    repeat (4) @(negedge clk);
    check("R9 irq up", irq, 1);
    repeat (2) @(negedge clk);
    wr(12'h00C, 32'h0);            // lands on edge 8, the second expiry
    rd(12'h014, v); check("R9 cleared", v, 0);
    check("R9 no reset", rst_req, 0);
    rd(12'h004, v); check("R9 reloaded", v, 3);
    // R9 locked clear ignored
    repeat (4) @(negedge clk);
    wr(12'hC00, 0);
    wr(12'h00C, 32'hDEAD);
    rd(12'h014, v); check("R3 locked clear ignored", v, 1);

    // R10 freeze
    start(3, 1'b0);
    repeat (4) @(negedge clk);
    wr(12'h008, 0);
    check("R10 irq low", irq, 0);
    rd(12'h014, v); check("R10 pending kept", v, 1);
    rd(12'h004, v);
    repeat (6) @(negedge clk);
    rd(12'h004, v2); check("R10 frozen", v2, v);
    wr(12'h008, 1);
    check("R10 irq back", irq, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule